// File: doc/BRIEF.md
# External Pseudo-Static RAM Startup Sequencer

After reset this block brings an external pseudo-static RAM from an unknown state to quad operation, or decides that no such device is fitted. It drives chip select, a slow serial clock and four data lines through one shared frame engine. The serial clock runs at the system clock divided by a parameter. It first sends a four-line frame that makes the device leave quad mode, in case an earlier boot left it there. It then reads the identification bytes in single-line mode.

The device counts as present only when one particular identification byte holds the expected good-die value. In that case the block decodes a size from the extended identification byte, then sends a reset-enable frame, a reset frame and a quad-enable frame, each as a chip-select frame of its own. When the device is absent, the sequence stops after the identification frame. In both cases a sticky done flag tells the access engine that it may start. Alongside it come a present flag and a three-bit size code.

Top module: `psram_init_seq`

## Requirements
- R1: The first frame after reset carries one byte, 0xF5, on all four data lines (dq_oe = 4'b1111). The high nibble goes out first, so the frame has exactly 2 serial clock pulses.
- R2: The second frame is a single-line frame of 7 byte slots, 56 clock pulses in all, with dq_oe = 4'b0001. Slot 0 sends 0x9F and slots 1 to 6 send 0xFF, each byte most significant bit first on dq_out[0].
- R3: Response bits are sampled from miso at each rising serial clock edge, most significant bit first. The byte in slot 5 decides presence: the device is present exactly when it equals 0x5D. The bytes in slots 0 to 4 have no effect.
- R4: size_code takes the byte in slot 6 as its source, using this encoding: 0 = none, 1 = 1 MiB, 2 = 2 MiB, 3 = 4 MiB, 4 = 8 MiB. The code is 4 when the byte is 0x26 or its bits [7:5] equal 2. It is 2 when bits [7:5] equal 0 and 3 when they equal 1. Any other value gives 1.
- R5: When the device is absent, present and size_code stay 0, done is set, and no further chip-select frame is sent.
- R6: When the device is present, three single-line one-byte frames follow in this order: 0x66, 0x99, 0x35.
- R7: Between two frames, chip select stays high for at least GAP_CYCLES system cycles. While chip select is high, the serial clock is low.
- R8: Every half period of the serial clock, and the delay from a chip-select fall to the first rising edge, lasts CLK_DIV/2 system cycles.
- R9: done rises exactly one system cycle after chip select rises at the end of the last frame. After that, done, present and size_code hold their values until reset.
- R10: While reset is asserted, cs_n = 1, sck = 0, dq_oe = 0, done = 0, present = 0 and size_code = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| miso | input | 1 | Single-line response data from the device |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| dq_out | output | 4 | Data driven to the device |
| dq_oe | output | 4 | Per-line output enable |
| done | output | 1 | Sequence finished (sticky) |
| present | output | 1 | Good-die byte matched |
| size_code | output | 3 | Decoded capacity code |

## Verification
The bench sets the good-die byte to 0x5D and sweeps the extended identification byte through all 256 values. This separates every size class, the 0x26 special case from the rest of its class, and the boundaries between the class fields. It also runs with a set of wrong good-die bytes, including near misses that differ by one bit and 0x5D placed in slot 4. These runs show that presence depends on slot 5 alone and that an absent device receives no further frames. Every run also decodes each frame from the pins, so it checks the opcodes, line counts, clock pulse counts, half periods, gaps and the cycle on which done rises.

// File: rtl/psinit_pkg.sv
package psinit_pkg;

  localparam logic [7:0] OP_QUAD_EXIT = 8'hF5;
  localparam logic [7:0] OP_READ_ID   = 8'h9F;
  localparam logic [7:0] OP_FILL      = 8'hFF;
  localparam logic [7:0] OP_RST_EN    = 8'h66;
  localparam logic [7:0] OP_RST       = 8'h99;
  localparam logic [7:0] OP_QUAD_EN   = 8'h35;

  typedef enum logic [2:0] {
    SZ_NONE = 3'd0,
    SZ_1M   = 3'd1,
    SZ_2M   = 3'd2,
    SZ_4M   = 3'd3,
    SZ_8M   = 3'd4
  } size_code_e;

  typedef enum logic [2:0] {
    SQ_EXITQ, SQ_EXITQ_W, SQ_GAP_ID, SQ_ID_W, SQ_GAP_CMD, SQ_CMD_W, SQ_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    SH_IDLE, SH_LOW, SH_HIGH, SH_TAIL
  } sh_state_e;

  // Post-probe command list, issued in index order
  function automatic logic [7:0] cmd_op(input logic [1:0] idx);
    case (idx)
      2'd0:    cmd_op = OP_RST_EN;
      2'd1:    cmd_op = OP_RST;
      default: cmd_op = OP_QUAD_EN;
    endcase
  endfunction

endpackage

// File: rtl/psinit_clkgen.sv
module psinit_clkgen #(
  parameter int HALF = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt == CW'(HALF - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign tick = !clr && (cnt == CW'(HALF - 1));
endmodule

// File: rtl/psinit_shifter.sv
module psinit_shifter
  import psinit_pkg::*;
#(
  parameter int HALF   = 15,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              quad,
  input  logic [SLOT_W-1:0] last_slot,
  input  logic [7:0]        tx_first,
  input  logic [7:0]        tx_fill,
  input  logic              miso,
  output logic              sck,
  output logic              cs_n,
  output logic [3:0]        dq_out,
  output logic [3:0]        dq_oe,
  output logic              rx_valid,
  output logic [SLOT_W-1:0] rx_slot,
  output logic [7:0]        rx_byte,
  output logic              fin
);
  sh_state_e         st;
  logic              tick;
  logic              quad_q;
  logic [SLOT_W-1:0] last_q;
  logic [SLOT_W-1:0] slot;
  logic [2:0]        bitcnt;
  logic [7:0]        sh_tx;
  logic [7:0]        sh_rx;
  logic [2:0]        last_bit;

  psinit_clkgen #(.HALF(HALF)) u_clkgen (
    .clk (clk),
    .rst (rst),
    .clr (st == SH_IDLE),
    .tick(tick)
  );

  assign last_bit = quad_q ? 3'd1 : 3'd7;
  assign dq_out   = quad_q ? sh_tx[7:4] : {3'b000, sh_tx[7]};
  assign rx_byte  = sh_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SH_IDLE;
      cs_n     <= 1'b1;
      sck      <= 1'b0;
      dq_oe    <= 4'h0;
      quad_q   <= 1'b0;
      last_q   <= '0;
      slot     <= '0;
      bitcnt   <= '0;
      sh_tx    <= '0;
      sh_rx    <= '0;
      rx_valid <= 1'b0;
      rx_slot  <= '0;
      fin      <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      fin      <= 1'b0;
      case (st)
        SH_IDLE: begin
          if (start) begin
            cs_n   <= 1'b0;
            dq_oe  <= quad ? 4'hF : 4'h1;
            quad_q <= quad;
            last_q <= last_slot;
            slot   <= '0;
            bitcnt <= '0;
            sh_tx  <= tx_first;
            st     <= SH_LOW;
          end
        end
        SH_LOW: begin
          if (tick) begin
            sck   <= 1'b1;
            sh_rx <= {sh_rx[6:0], miso};
            st    <= SH_HIGH;
          end
        end
        SH_HIGH: begin
          if (tick) begin
            sck <= 1'b0;
            st  <= SH_LOW;
            if (bitcnt == last_bit) begin
              bitcnt   <= '0;
              rx_valid <= !quad_q;
              rx_slot  <= slot;
              if (slot == last_q) begin
                st <= SH_TAIL;
              end else begin
                slot  <= slot + SLOT_W'(1);
                sh_tx <= tx_fill;
              end
            end else begin
              bitcnt <= bitcnt + 3'd1;
              sh_tx  <= quad_q ? {sh_tx[3:0], 4'h0} : {sh_tx[6:0], 1'b0};
            end
          end
        end
        default: begin
          if (tick) begin
            cs_n  <= 1'b1;
            dq_oe <= 4'h0;
            fin   <= 1'b1;
            st    <= SH_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/psinit_size_dec.sv
module psinit_size_dec
  import psinit_pkg::*;
(
  input  logic [7:0] eid,
  output logic [2:0] code
);
  always_comb begin
    if (eid == 8'h26 || eid[7:5] == 3'd2) begin
      code = SZ_8M;
    end else if (eid[7:5] == 3'd0) begin
      code = SZ_2M;
    end else if (eid[7:5] == 3'd1) begin
      code = SZ_4M;
    end else begin
      code = SZ_1M;
    end
  end
endmodule

// File: rtl/psram_init_seq.sv
module psram_init_seq
  import psinit_pkg::*;
#(
  parameter int         CLK_DIV    = 30,
  parameter int         GAP_CYCLES = 20,
  parameter int         ID_SLOTS   = 7,
  parameter int         KGD_SLOT   = 5,
  parameter int         EID_SLOT   = 6,
  parameter logic [7:0] KGD_VALUE  = 8'h5D
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       miso,
  output logic       sck,
  output logic       cs_n,
  output logic [3:0] dq_out,
  output logic [3:0] dq_oe,
  output logic       done,
  output logic       present,
  output logic [2:0] size_code
);
  localparam int HALF   = CLK_DIV / 2;
  localparam int SLOT_W = $clog2(ID_SLOTS);
  localparam int GAP_W  = $clog2(GAP_CYCLES + 1);

  seq_state_e        st;
  logic [GAP_W-1:0]  gap_cnt;
  logic [1:0]        cmd_idx;
  logic [7:0]        kgd_q;
  logic [7:0]        eid_q;
  logic              start_q;
  logic              quad_q;
  logic [SLOT_W-1:0] last_slot_q;
  logic [7:0]        first_q;
  logic              rx_valid;
  logic [SLOT_W-1:0] rx_slot;
  logic [7:0]        rx_byte;
  logic              fin;
  logic [2:0]        dec_code;
  logic              gap_end;

  psinit_shifter #(.HALF(HALF), .SLOT_W(SLOT_W)) u_shifter (
    .clk      (clk),
    .rst      (rst),
    .start    (start_q),
    .quad     (quad_q),
    .last_slot(last_slot_q),
    .tx_first (first_q),
    .tx_fill  (OP_FILL),
    .miso     (miso),
    .sck      (sck),
    .cs_n     (cs_n),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .rx_valid (rx_valid),
    .rx_slot  (rx_slot),
    .rx_byte  (rx_byte),
    .fin      (fin)
  );

  psinit_size_dec u_size_dec (
    .eid (eid_q),
    .code(dec_code)
  );

  assign gap_end = (gap_cnt == GAP_W'(GAP_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SQ_EXITQ;
      gap_cnt     <= '0;
      cmd_idx     <= '0;
      kgd_q       <= '0;
      eid_q       <= '0;
      start_q     <= 1'b0;
      quad_q      <= 1'b0;
      last_slot_q <= '0;
      first_q     <= '0;
      done        <= 1'b0;
      present     <= 1'b0;
      size_code   <= SZ_NONE;
    end else begin
      start_q <= 1'b0;
      if (rx_valid && rx_slot == SLOT_W'(KGD_SLOT)) kgd_q <= rx_byte;
      if (rx_valid && rx_slot == SLOT_W'(EID_SLOT)) eid_q <= rx_byte;
      case (st)
        SQ_EXITQ: begin
          start_q     <= 1'b1;
          quad_q      <= 1'b1;
          first_q     <= OP_QUAD_EXIT;
          last_slot_q <= '0;
          st          <= SQ_EXITQ_W;
        end
        SQ_EXITQ_W: begin
          if (fin) begin
            gap_cnt <= '0;
            st      <= SQ_GAP_ID;
          end
        end
        SQ_GAP_ID: begin
          gap_cnt <= gap_cnt + GAP_W'(1);
          if (gap_end) begin
            start_q     <= 1'b1;
            quad_q      <= 1'b0;
            first_q     <= OP_READ_ID;
            last_slot_q <= SLOT_W'(ID_SLOTS - 1);
            st          <= SQ_ID_W;
          end
        end
        SQ_ID_W: begin
          if (fin) begin
            if (kgd_q == KGD_VALUE) begin
              present   <= 1'b1;
              size_code <= dec_code;
              cmd_idx   <= '0;
              gap_cnt   <= '0;
              st        <= SQ_GAP_CMD;
            end else begin
              done <= 1'b1;
              st   <= SQ_FIN;
            end
          end
        end
        SQ_GAP_CMD: begin
          gap_cnt <= gap_cnt + GAP_W'(1);
          if (gap_end) begin
            start_q     <= 1'b1;
            quad_q      <= 1'b0;
            first_q     <= cmd_op(cmd_idx);
            last_slot_q <= '0;
            st          <= SQ_CMD_W;
          end
        end
        SQ_CMD_W: begin
          if (fin) begin
            if (cmd_idx == 2'd2) begin
              done <= 1'b1;
              st   <= SQ_FIN;
            end else begin
              cmd_idx <= cmd_idx + 2'd1;
              gap_cnt <= '0;
              st      <= SQ_GAP_CMD;
            end
          end
        end
        default: st <= SQ_FIN;
      endcase
    end
  end
endmodule

// File: rtl/psinit_checker.sv
module psinit_checker (
  input logic       clk,
  input logic       rst,
  input logic       sck,
  input logic       cs_n,
  input logic [3:0] dq_oe,
  input logic       done,
  input logic       present,
  input logic [2:0] size_code
);
  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sck); // R7
  AST_OE_SHAPE: assert property (@(posedge clk) disable iff (rst) (dq_oe == 4'h0 || dq_oe == 4'h1 || dq_oe == 4'hF)); // R2
  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (rst) cs_n |-> dq_oe == 4'h0); // R1
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst) done |=> done); // R9
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst) done |=> ($stable(size_code) && $stable(present))); // R9
  AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (rst) (done && !present) |-> size_code == 3'd0); // R5
  AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (rst) present |-> (size_code >= 3'd1 && size_code <= 3'd4)); // R4
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst) done |-> cs_n); // R5
endmodule

bind psram_init_seq psinit_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .sck      (sck),
  .cs_n     (cs_n),
  .dq_oe    (dq_oe),
  .done     (done),
  .present  (present),
  .size_code(size_code)
);

// File: tb/psram_init_seq_bench.sv
module psram_init_seq_bench;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int GAP  = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       miso;
  logic       sck, cs_n, done, present;
  logic [3:0] dq_out, dq_oe;
  logic [2:0] size_code;

  always #2 clk = ~clk;

  psram_init_seq #(.CLK_DIV(DIV), .GAP_CYCLES(GAP)) u_psram_init_seq (
    .clk(clk), .rst(rst), .miso(miso), .sck(sck), .cs_n(cs_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .done(done), .present(present),
    .size_code(size_code)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Device model: response byte per slot, bit pointer advanced on falling sck
  logic [7:0] resp [7];
  int bitcnt;
  always_comb begin
    if (bitcnt < 56) miso = resp[bitcnt / 8][7 - (bitcnt % 8)];
    else miso = 1'b1;
  end

  // Pin-level frame recorder
  int          frame_cnt, rises, hp_bad, idle_bad, min_gap, done_cyc, last_end, last_edge;
  logic [63:0] sb;
  logic [7:0]  qb;
  logic        prev_cs, prev_sck;
  int          f_rise [8];
  logic [3:0]  f_oe   [8];
  logic [63:0] f_s    [8];
  logic [7:0]  f_q    [8];

  always @(negedge clk) begin
    if (rst) begin
      frame_cnt = 0; bitcnt = 0; prev_cs = 1'b1; prev_sck = 1'b0;
      hp_bad = 0; idle_bad = 0; min_gap = 1000000; done_cyc = -1;
      last_end = 0; last_edge = 0; rises = 0; sb = '0; qb = '0;
    end else begin
      if (cs_n && sck) idle_bad++;
      if (!cs_n && prev_cs) begin
        if (frame_cnt > 0 && (cyc - last_end) < min_gap) min_gap = cyc - last_end;
        rises = 0; sb = '0; qb = '0; bitcnt = 0; last_edge = cyc;
        if (frame_cnt < 8) f_oe[frame_cnt] = dq_oe;
      end
      if (sck && !prev_sck) begin
        if (cyc - last_edge != HALF) hp_bad++;
        last_edge = cyc; rises++;
        sb = {sb[62:0], dq_out[0]};
        qb = {qb[3:0], dq_out};
      end
      if (!sck && prev_sck) begin
        if (cyc - last_edge != HALF) hp_bad++;
        last_edge = cyc; bitcnt++;
      end
      if (cs_n && !prev_cs) begin
        if (frame_cnt < 8) begin
          f_rise[frame_cnt] = rises; f_s[frame_cnt] = sb; f_q[frame_cnt] = qb;
        end
        frame_cnt++; last_end = cyc;
      end
      if (done && done_cyc < 0) done_cyc = cyc;
      prev_cs = cs_n; prev_sck = sck;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_size(input logic [7:0] e);
    if (e == 8'h26 || e[7:5] == 3'd2) return 4;
    if (e[7:5] == 3'd0) return 2;
    if (e[7:5] == 3'd1) return 3;
    return 1;
  endfunction

  task automatic run_case(input logic [7:0] kgd, input logic [7:0] eid,
                          input logic [7:0] slot4, input bit chk_reset);
    bit pres;
    int nfr;
    logic [2:0] sz_done;
    logic [7:0] ops [3];
    ops[0] = 8'h66; ops[1] = 8'h99; ops[2] = 8'h35;
    resp[0] = 8'hA5; resp[1] = 8'h12; resp[2] = 8'h34; resp[3] = 8'h56;
    resp[4] = slot4; resp[5] = kgd; resp[6] = eid;
    pres = (kgd == 8'h5D);
    nfr  = pres ? 5 : 2;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    if (chk_reset)
      check(cs_n === 1'b1 && sck === 1'b0 && dq_oe === 4'h0 && done === 1'b0 &&
            present === 1'b0 && size_code === 3'd0, "R10 reset state",
            {cs_n, sck, dq_oe, done, present, size_code}, {1'b1, 9'h0});
    rst = 1'b0;
    for (int i = 0; i < 4000 && done !== 1'b1; i++) @(negedge clk);
    sz_done = size_code;
    repeat (40) @(negedge clk);

    check(f_rise[0] == 2 && f_oe[0] === 4'hF && f_q[0] === 8'hF5, "R1 quad exit frame",
          {f_rise[0][7:0], f_oe[0], f_q[0]}, {8'd2, 4'hF, 8'hF5});
    check(f_rise[1] == 56 && f_oe[1] === 4'h1 && f_s[1][55:0] === {8'h9F, 48'hFFFF_FFFF_FFFF},
          "R2 id frame", f_s[1], {8'h9F, 48'hFFFF_FFFF_FFFF});
    check(present === pres, "R3 present", present, pres);
    check(size_code === (pres ? 3'(exp_size(eid)) : 3'd0), "R4 size code",
          size_code, pres ? exp_size(eid) : 0);
    if (!pres) check(frame_cnt == nfr, "R5 no frames after absent", frame_cnt, nfr);
    else begin
      check(frame_cnt == nfr, "R6 frame count", frame_cnt, nfr);
      for (int k = 0; k < 3; k++)
        check(f_rise[k+2] == 8 && f_oe[k+2] === 4'h1 && f_s[k+2][7:0] === ops[k],
              "R6 command frame", {f_rise[k+2][7:0], f_oe[k+2], f_s[k+2][7:0]},
              {8'd8, 4'h1, ops[k]});
    end
    check(min_gap >= GAP && idle_bad == 0, "R7 deselect gap", min_gap, GAP);
    check(hp_bad == 0, "R8 half period", hp_bad, 0);
    check(done === 1'b1 && done_cyc - last_end == 1 && sz_done === size_code,
          "R9 done timing", done_cyc - last_end, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    for (int e = 0; e < 256; e++) run_case(8'h5D, 8'(e), 8'h0D, e == 0);
    run_case(8'h00, 8'h40, 8'h5D, 1'b0);
    run_case(8'h5C, 8'h40, 8'h5D, 1'b0);
    run_case(8'hDD, 8'h26, 8'h5D, 1'b0);
    run_case(8'h5F, 8'h00, 8'h5D, 1'b0);
    run_case(8'hFF, 8'hFF, 8'h5D, 1'b0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule